// File: doc/BRIEF.md
# Serial EEPROM Host Controller

This block lets on-chip logic use a 16-bit-word serial EEPROM through a plain parallel request port. A one-cycle start strobe carries a request type (read a word, write a word, unlock writes, lock writes), an 8-bit word address and 16 bits of write data. The block then drives the memory's active-low chip select, its serial clock and its serial input. It also watches the memory's serial output, which reaches the block through a configurable synchronizer.

Every instruction is sent as one frame with its most significant bit first. The frame holds a fixed lead-in of 1010, a 4-bit instruction code and the address. A write frame carries 16 data bits as well. A read frame continues for 16 more clocks while the returned word is collected. After a write, chip select stays low and the controller polls the memory's output until the memory reports ready. The controller then clocks one `1` bit in to release that line and ends the frame. If the memory never reports ready, a timeout ends the poll and the controller reports an error. Each request ends with a one-cycle done pulse, and the read word is valid during that pulse.

Top module: `sereep_host`

## Requirements
- R1: While reset is held and right after it, `ee_cs_n`=1, `ee_sk`=0, `ee_di`=0, `busy`=0, `rsp_done`=0 and `rsp_err`=0.
- R2: `req_op` is encoded 0=read, 1=write, 2=unlock, 3=lock. The frame starts with the bits 1010. The instruction code follows: read 1000, write 0100, unlock 0011, lock 0000. The 8 address bits come next, MSB first. Unlock and lock send zero address bits.
- R3: Each high phase of `ee_sk` lasts exactly CLK_DIV system clocks. `ee_di` changes only while `ee_sk` is low, so it is steady across every rising edge.
- R4: A read gives 32 serial clocks. The word is collected MSB first from `ee_do` at the rising edges of clocks 17 to 32, and appears on `rsp_rdata` while `rsp_done` is high.
- R5: A write gives 32 serial clocks. Clocks 17 to 32 carry `req_wdata`, MSB first.
- R6: After a write, `ee_cs_n` stays low until `ee_do` reads high. The block then gives one extra serial clock with `ee_di`=1 before it releases chip select, and `rsp_done` comes only after the memory became ready.
- R7: If `ee_do` stays low for POLL_MAX system clocks of polling, the request ends with `rsp_err`=1 together with `rsp_done`. Otherwise `rsp_err` is 0.
- R8: `ee_cs_n` is high whenever the block is idle, `ee_sk` is low whenever `ee_cs_n` is high, and chip select is high for at least CLK_DIV clocks before `rsp_done`.
- R9: `rsp_done` is a one-cycle pulse. An accepted start makes `busy` high on the next cycle, and `busy` is low again in the done cycle. A start seen while `busy` is high has no effect.
- R10: Unlock and lock take (2*16+3)*CLK_DIV cycles of `busy`, and a read takes (2*32+3)*CLK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-cycle request strobe |
| req_op | input | 2 | Request type (0 read, 1 write, 2 unlock, 3 lock) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rsp_rdata | output | DATA_W | Word read, valid with `rsp_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write poll timed out, valid with `rsp_done` |
| busy | output | 1 | Request in progress |
| ee_cs_n | output | 1 | Memory chip select, active low |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench contains a behavioural memory that decodes each frame. Each request type is sent to it, and the decoded lead-in, code, address and data show whether framing and bit order are right. Reads of addresses 0x00, 0x12 and 0xFF, filled with patterns whose high and low bits differ, show whether the capture edge is one clock off or the word is reversed. Writes are sent to a memory that turns ready after a set delay and to one that never does, which separates a correct poll from an early done and from a missing timeout. A start injected during a read shows whether requests are ignored while busy.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

   typedef enum logic [1:0] {
      REQ_READ  = 2'd0,
      REQ_WRITE = 2'd1,
      REQ_WREN  = 2'd2,
      REQ_WRDIS = 2'd3
   } req_op_e;

   localparam logic [3:0] FRAME_LEAD = 4'b1010;

   typedef enum logic [3:0] {
      S_IDLE, S_SETUP, S_LOW, S_HIGH, S_POLL, S_FL_LO, S_FL_HI, S_HOLD, S_GAP
   } st_e;

   function automatic logic [3:0] op_code(input req_op_e op);
      case (op)
         REQ_READ:  op_code = 4'b1000;
         REQ_WRITE: op_code = 4'b0100;
         REQ_WREN:  op_code = 4'b0011;
         default:   op_code = 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/sereep_phase_tick.sv
module sereep_phase_tick #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (CLK_DIV == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!run)           cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sereep_sync.sv
module sereep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '1;
            else begin
               r_q[0] <= d;
               for (int i = 1; i < STAGES; i++) r_q[i] <= r_q[i-1];
            end
         end
         assign q = r_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sereep_poll_timer.sv
module sereep_poll_timer #(
   parameter int POLL_MAX = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int PW = $clog2(POLL_MAX + 1);
   localparam logic [PW-1:0] LIMIT = PW'(POLL_MAX - 1);
   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == LIMIT);
endmodule

// File: rtl/sereep_host.sv
module sereep_host
   import sereep_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int POLL_MAX    = 4096,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic              busy,
   output logic              ee_cs_n,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);
   localparam int CMD_BITS   = 8 + ADDR_W;
   localparam int FRAME_BITS = CMD_BITS + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CMD_CNT   = CNT_W'(CMD_BITS);
   localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);

   generate
      if (CLK_DIV < 1)            begin : g_bad_div   $error("CLK_DIV must be at least 1");            end
      if (CLK_DIV <= SYNC_STAGES) begin : g_bad_sync  $error("CLK_DIV must exceed SYNC_STAGES");       end
      if (POLL_MAX < 2)           begin : g_bad_poll  $error("POLL_MAX must be at least 2");           end
      if (DATA_W < 2)             begin : g_bad_data  $error("DATA_W must be at least 2");             end
      if (ADDR_W < 1)             begin : g_bad_addr  $error("ADDR_W must be at least 1");             end
   endgenerate

   st_e                   st_q;
   logic [FRAME_BITS-1:0] frame_q;
   logic [CNT_W-1:0]      nclk_q, bitcnt_q;
   logic                  is_read_q, is_write_q, to_q;
   logic [DATA_W-1:0]     rd_q;
   logic                  cs_n_q, sk_q, di_q, done_q, err_q;
   logic                  tick, do_s, expired, tick_run;
   logic [FRAME_BITS-1:0] frame_d;
   req_op_e               op;

   assign op       = req_op_e'(req_op);
   assign tick_run = (st_q != S_IDLE) && (st_q != S_POLL);

   sereep_phase_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(tick_run), .tick(tick));

   sereep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ee_do), .q(do_s));

   sereep_poll_timer #(.POLL_MAX(POLL_MAX)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q == S_POLL), .expired(expired));

   always_comb begin
      frame_d = {FRAME_LEAD, op_code(op), {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
      if (op == REQ_READ || op == REQ_WRITE) frame_d[DATA_W +: ADDR_W] = req_addr;
      if (op == REQ_WRITE)                   frame_d[0 +: DATA_W]      = req_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE;   frame_q <= '0;  nclk_q <= '0;  bitcnt_q <= '0;
         is_read_q <= 1'b0; is_write_q <= 1'b0; to_q <= 1'b0; rd_q <= '0;
         cs_n_q <= 1'b1;   sk_q <= 1'b0;   di_q <= 1'b0;
         done_q <= 1'b0;   err_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            S_IDLE: if (req_start) begin
               frame_q    <= frame_d;
               nclk_q     <= (op == REQ_READ || op == REQ_WRITE) ? FRAME_CNT : CMD_CNT;
               is_read_q  <= (op == REQ_READ);
               is_write_q <= (op == REQ_WRITE);
               bitcnt_q   <= '0;
               to_q       <= 1'b0;
               cs_n_q     <= 1'b0;
               st_q       <= S_SETUP;
            end
            S_SETUP: if (tick) begin
               di_q    <= frame_q[FRAME_BITS-1];
               frame_q <= frame_q << 1;
               st_q    <= S_LOW;
            end
            S_LOW: if (tick) begin
               sk_q     <= 1'b1;
               bitcnt_q <= bitcnt_q + 1'b1;
               if (is_read_q && bitcnt_q >= CMD_CNT) rd_q <= {rd_q[DATA_W-2:0], do_s};
               st_q     <= S_HIGH;
            end
            S_HIGH: if (tick) begin
               sk_q <= 1'b0;
               if (bitcnt_q == nclk_q) begin
                  di_q <= 1'b0;
                  st_q <= is_write_q ? S_POLL : S_HOLD;
               end else begin
                  di_q    <= frame_q[FRAME_BITS-1];
                  frame_q <= frame_q << 1;
                  st_q    <= S_LOW;
               end
            end
            S_POLL: begin
               if (do_s) begin
                  di_q <= 1'b1;
                  st_q <= S_FL_LO;
               end else if (expired) begin
                  to_q <= 1'b1;
                  st_q <= S_HOLD;
               end
            end
            S_FL_LO: if (tick) begin
               sk_q <= 1'b1;
               st_q <= S_FL_HI;
            end
            S_FL_HI: if (tick) begin
               sk_q <= 1'b0;
               di_q <= 1'b0;
               st_q <= S_HOLD;
            end
            S_HOLD: if (tick) begin
               cs_n_q <= 1'b1;
               st_q   <= S_GAP;
            end
            S_GAP: if (tick) begin
               done_q <= 1'b1;
               err_q  <= to_q;
               st_q   <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign rsp_rdata = rd_q;
   assign rsp_done  = done_q;
   assign rsp_err   = err_q;
   assign busy      = (st_q != S_IDLE);
   assign ee_cs_n   = cs_n_q;
   assign ee_sk     = sk_q;
   assign ee_di     = di_q;
endmodule

// File: rtl/sereep_host_chk.sv
module sereep_host_chk #(
   parameter int CLK_DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_start,
   input logic busy,
   input logic rsp_done,
   input logic rsp_err,
   input logic ee_cs_n,
   input logic ee_sk,
   input logic ee_di
);
   logic [15:0] hi_len, cs_hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len    <= '0;
         cs_hi_len <= '0;
      end else begin
         hi_len    <= ee_sk   ? ((hi_len    == 16'hFFFF) ? hi_len    : hi_len + 1'b1)    : '0;
         cs_hi_len <= ee_cs_n ? ((cs_hi_len == 16'hFFFF) ? cs_hi_len : cs_hi_len + 1'b1) : '0;
      end
   end

   p_sk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs_n |-> !ee_sk);
   p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ee_cs_n);
   p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (cs_hi_len >= 16'(CLK_DIV)));
   p_di_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_sk) |-> $stable(ee_di));
   p_hi_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_sk) |-> (hi_len == 16'(CLK_DIV)));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !busy);
   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && !busy) |=> busy);
   p_err_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);
endmodule

bind sereep_host sereep_host_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_start(req_start), .busy(busy),
   .rsp_done(rsp_done), .rsp_err(rsp_err), .ee_cs_n(ee_cs_n),
   .ee_sk(ee_sk), .ee_di(ee_di));

// File: tb/sereep_host_test.sv
module sereep_host_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int D        = 4;
   localparam int PM       = 80;
   localparam int BUSY_CYC = 30;
   localparam int LAT_RD   = (2*32+3)*D;
   localparam int LAT_CMD  = (2*16+3)*D;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_start = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [7:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata;
   logic rsp_done, rsp_err, busy, ee_cs_n, ee_sk, ee_di, ee_do;

   int checks = 0, errors = 0, cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sereep_host #(.CLK_DIV(D), .POLL_MAX(PM), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy), .ee_cs_n(ee_cs_n),
      .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

   // ---------------- behavioural serial memory ----------------
   logic [15:0] mem [256];
   logic wen = 1'b0, rd_mode = 1'b0, polling = 1'b0, stuck = 1'b0, do_q = 1'b1, flush_seen = 1'b0;
   logic [31:0] sh = '0;
   logic [3:0] op4 = '0, last_lead = '0, last_op = '0;
   logic [7:0] cur_addr = '0, last_addr = '0;
   logic [15:0] rd_word = '0, last_data = '0;
   int bitc = 0, rd_idx = -1, frames = 0, busy_until = 0;

   function automatic logic [15:0] init_val(input int a);
      init_val = 16'(a * 16'h0137) ^ 16'h5A5A;
   endfunction

   initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);

   assign ee_do = polling ? (stuck ? 1'b0 : (cyc >= busy_until)) : (rd_mode ? do_q : 1'b1);

   always @(negedge ee_cs_n) begin bitc = 0; rd_mode = 1'b0; rd_idx = -1; end
   always @(posedge ee_cs_n) begin rd_mode = 1'b0; polling = 1'b0; end

   always @(posedge ee_sk) if (!ee_cs_n) begin
      sh = {sh[30:0], ee_di};
      bitc++;
      if (polling && bitc > 32 && ee_di) flush_seen = 1'b1;
      if (bitc == 16) begin
         last_lead = sh[15:12];
         op4 = sh[11:8];
         cur_addr = sh[7:0];
         last_op = op4; last_addr = cur_addr;
         frames++;
         if (sh[15:12] == 4'b1010) begin
            if (op4 == 4'b1000) begin rd_mode = 1'b1; rd_word = mem[cur_addr]; rd_idx = 15; end
            if (op4 == 4'b0011) wen = 1'b1;
            if (op4 == 4'b0000) wen = 1'b0;
         end
      end
      if (bitc == 32 && op4 == 4'b0100) begin
         last_data = sh[15:0];
         if (wen) begin mem[cur_addr] = sh[15:0]; busy_until = cyc + BUSY_CYC; end
         else busy_until = cyc;
         polling = 1'b1;
      end
   end

   always @(negedge ee_sk) if (!ee_cs_n && rd_mode && bitc >= 16 && rd_idx >= 0) begin
      do_q = rd_word[rd_idx];
      rd_idx--;
   end

   // ---------------- checking helpers ----------------
   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // per-clock reference of the serial pin timing, sampled away from the edge
   int sk_hi_run = 0, cs_hi_run = 1000;
   logic sk_prev = 1'b0, di_prev = 1'b0, cs_prev = 1'b1, done_prev = 1'b0;
   always @(negedge clk) if (rst_n) begin
      if (sk_prev && !ee_sk) check("R3 sk high-phase length", sk_hi_run, D);
      if (sk_prev && ee_sk && ee_di !== di_prev) check("R3 di moved while sk high", ee_di, di_prev);
      if (cs_prev && !ee_cs_n) check("R8 chip select high time before frame", 32'(cs_hi_run >= D), 1);
      if (!busy) check("R8 idle pins cs_n/sk", {ee_cs_n, ee_sk}, 2'b10);
      if (done_prev) check("R9 done single cycle", rsp_done, 1'b0);
      sk_hi_run = ee_sk ? sk_hi_run + 1 : 0;
      cs_hi_run = ee_cs_n ? cs_hi_run + 1 : 0;
      sk_prev = ee_sk; di_prev = ee_di; cs_prev = ee_cs_n; done_prev = rsp_done;
   end

   task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd,
                         input int inject_at, output logic [15:0] rd, output logic e,
                         output int lat, output int dcyc);
      int guard;
      @(negedge clk);
      req_op = op; req_addr = a; req_wdata = wd; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check("R9 busy after accepted start", busy, 1'b1);
      lat = 0; guard = 0;
      while (!rsp_done && guard < 5000) begin
         if (busy) lat++;
         if (guard == inject_at) begin
            req_op = 2'd1; req_addr = 8'h55; req_wdata = 16'hDEAD; req_start = 1'b1;
         end else req_start = 1'b0;
         guard++;
         @(negedge clk);
      end
      req_start = 1'b0;
      if (guard >= 5000) check("R9 request never completed", 0, 1);
      check("R9 busy low in done cycle", busy, 1'b0);
      rd = rsp_rdata; e = rsp_err; dcyc = cyc;
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      logic e;
      int lat, dcyc, fr0;

      repeat (3) @(negedge clk);
      check("R1 reset pins", {ee_cs_n, ee_sk, ee_di, busy, rsp_done, rsp_err}, 6'b100000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pins after reset", {ee_cs_n, ee_sk, ee_di, busy, rsp_done, rsp_err}, 6'b100000);

      // read before unlock
      run_op(2'd0, 8'h12, 16'h0, -1, rd, e, lat, dcyc);
      check("R2 lead-in", last_lead, 4'b1010);
      check("R2 read code", last_op, 4'b1000);
      check("R2 read address", last_addr, 8'h12);
      check("R4 read data 0x12", rd, init_val(8'h12));
      check("R10 read latency", lat, LAT_RD);
      check("R7 no error on read", e, 1'b0);

      // write while locked: memory ignores it, controller still completes
      run_op(2'd1, 8'h12, 16'h1234, -1, rd, e, lat, dcyc);
      check("R2 write code", last_op, 4'b0100);
      check("R5 write data bits", last_data, 16'h1234);
      check("R7 no error on write", e, 1'b0);
      run_op(2'd0, 8'h12, 16'h0, -1, rd, e, lat, dcyc);
      check("R4 locked write left word", rd, init_val(8'h12));

      // unlock
      run_op(2'd2, 8'hAB, 16'hFFFF, -1, rd, e, lat, dcyc);
      check("R2 unlock code", last_op, 4'b0011);
      check("R2 unlock address zero", last_addr, 8'h00);
      check("R10 unlock latency", lat, LAT_CMD);

      // write with busy poll
      flush_seen = 1'b0;
      run_op(2'd1, 8'h12, 16'hBEEF, -1, rd, e, lat, dcyc);
      check("R5 write data 0xBEEF", last_data, 16'hBEEF);
      check("R6 done after ready", 32'(dcyc >= busy_until), 1);
      check("R6 release bit clocked", flush_seen, 1'b1);
      check("R7 no error after ready", e, 1'b0);
      run_op(2'd0, 8'h12, 16'h0, -1, rd, e, lat, dcyc);
      check("R4 read back 0xBEEF", rd, 16'hBEEF);

      // address and data boundaries
      run_op(2'd1, 8'hFF, 16'h8001, -1, rd, e, lat, dcyc);
      check("R2 write address 0xFF", last_addr, 8'hFF);
      run_op(2'd1, 8'h00, 16'h7FFE, -1, rd, e, lat, dcyc);
      run_op(2'd0, 8'hFF, 16'h0, -1, rd, e, lat, dcyc);
      check("R4 read back 0x8001", rd, 16'h8001);
      run_op(2'd0, 8'h00, 16'h0, -1, rd, e, lat, dcyc);
      check("R4 read back 0x7FFE", rd, 16'h7FFE);

      // lock, then a write must not land
      run_op(2'd3, 8'h77, 16'h0, -1, rd, e, lat, dcyc);
      check("R2 lock code", last_op, 4'b0000);
      check("R10 lock latency", lat, LAT_CMD);
      run_op(2'd1, 8'h34, 16'h0000, -1, rd, e, lat, dcyc);
      run_op(2'd0, 8'h34, 16'h0, -1, rd, e, lat, dcyc);
      check("R4 locked address 0x34 unchanged", rd, init_val(8'h34));

      // memory that never becomes ready
      run_op(2'd2, 8'h00, 16'h0, -1, rd, e, lat, dcyc);
      stuck = 1'b1;
      run_op(2'd1, 8'h40, 16'h4242, -1, rd, e, lat, dcyc);
      check("R7 timeout error flag", e, 1'b1);
      check("R7 poll lasted POLL_MAX", 32'(lat >= PM), 1);
      stuck = 1'b0;
      run_op(2'd0, 8'h12, 16'h0, -1, rd, e, lat, dcyc);
      check("R7 error cleared next request", e, 1'b0);

      // start strobe while busy is ignored
      fr0 = frames;
      run_op(2'd0, 8'hFF, 16'h0, 30, rd, e, lat, dcyc);
      check("R9 read unaffected by extra start", rd, 16'h8001);
      check("R9 latency unaffected", lat, LAT_RD);
      repeat (20) @(negedge clk);
      check("R9 no extra frame", frames - fr0, 1);
      check("R9 idle after ignored start", busy, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule